// File: doc/BRIEF.md
# Gated Clock Output Controller

This block produces an external clock output from an internal oscillator. It divides the oscillator by a ratio chosen from two control bits: a demodulator-mode bit and a frequency-select bit. It then gates the divided clock under two further bits, an output-disable bit and an intermittent bit. In continuous mode the divided clock is driven out at all times. With the disable bit set, the pin is held low. In intermittent mode the clock runs only while the attached receiver needs it.

In intermittent mode the receiver asks to leave its Off state through a wake request. The block starts the clock and lets a guard number of output pulses pass. Only then does it grant the wake, so the receiver sees clocks before it leaves Off. When the receiver returns to Off, the block lets the same guard number of pulses pass before it stops the clock. Every automatic start and stop happens during a low phase of the divided clock, so no pulse is ever shortened. A direct write to the disable bit acts at once and may cut a pulse short.

There are two reset inputs. The power-on reset clears the divider and the output path. The chip reset clears the control bits and the sequencer. While only the chip reset is held, the control bits sit at their reset values, which select continuous mode. The output therefore keeps toggling at the external-mode ratio.

Top module: `gated_clkout_ctrl`

## Requirements
- R1: While `por_n` is low, `clk_out` is low. After both resets the control bits are all 0 and `clk_out` toggles continuously, high and low for `HALF_EXT_F0` oscillator cycles each.
- R2: With the disable and intermittent bits clear, each `clk_out` high phase lasts the half period selected by `{cfg_wdata[2], cfg_wdata[3]}` = {internal-demod, freq-alt}: 00 gives `HALF_EXT_F0`, 01 gives `HALF_EXT_F1`, 10 gives `HALF_INT_F0` and 11 gives `HALF_INT_F1`.
- R3: While the disable bit (`cfg_wdata[0]`) is set, `clk_out` stays low, whatever the intermittent bit and the receiver inputs are.
- R4: In intermittent mode (`cfg_wdata[1]` = 1, disable clear), with the receiver Off and no wake request, `clk_out` stays low and `rx_wake_grant` is low.
- R5: In intermittent mode, after `rx_wake_req` rises, `rx_wake_grant` rises on the same oscillator edge as the `GUARD`-th rising edge of `clk_out`. No earlier edge raises it.
- R6: In intermittent mode, after `rx_off` returns high with no wake request, `clk_out` gives exactly `GUARD` further rising edges and then stays low.
- R7: Every `clk_out` high phase produced in intermittent mode, including the first and last of a run, lasts the full selected half period.
- R8: While `rst_n` is low and `por_n` is high, `clk_out` toggles with half period `HALF_EXT_F0`, and `rx_wake_grant` is high.
- R9: Outside intermittent mode, `rx_off` and `rx_wake_req` have no effect on `clk_out`, and `rx_wake_grant` is high.
- R10: The control bits change only on an oscillator edge where `cfg_we` is high. Data on `cfg_wdata` while `cfg_we` is low does not change the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Internal oscillator |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert; clears divider and output path |
| rst_n | input | 1 | Chip reset, active low, asynchronous assert; clears control bits and sequencer |
| cfg_we | input | 1 | Control write strobe |
| cfg_wdata | input | 4 | Control data: bit0 disable, bit1 intermittent, bit2 internal-demod, bit3 freq-alt |
| rx_off | input | 1 | Receiver is in its Off state |
| rx_wake_req | input | 1 | Receiver asks to leave Off |
| rx_wake_grant | output | 1 | Receiver may leave Off |
| clk_out | output | 1 | Gated, divided clock output |

## Verification
The bench builds the block with four different half periods (1, 2, 3 and 4 oscillator cycles), so every decode of the two ratio bits gives a pulse width that no other decode gives. It sets the guard count to 3. That keeps the lead and trail windows short enough to count edge by edge, and an off-by-one in the guard counter gives a count of 2 or 4 that the bench reports. The intermittent runs use a three-cycle half period, so a runt at a start or stop shows as a shorter high phase.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

  typedef enum logic [1:0] {
    GS_IDLE,
    GS_LEAD,
    GS_RUN,
    GS_TRAIL
  } gate_st_e;

  // Control word; bit 0 is out_dis, bit 3 is freq_alt
  typedef struct packed {
    logic freq_alt;
    logic int_demod;
    logic intermit;
    logic out_dis;
  } ctl_t;

endpackage

// File: rtl/clkgate_ctl_regs.sv
module clkgate_ctl_regs
  import clkgate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [3:0] wdata,
  output ctl_t       ctl_q
);

  ctl_t ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (we) ctl_d = ctl_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

endmodule

// File: rtl/clkgate_divider.sv
module clkgate_divider #(
  parameter int HALF_EXT_F0 = 1,
  parameter int HALF_EXT_F1 = 1,
  parameter int HALF_INT_F0 = 2,
  parameter int HALF_INT_F1 = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic [1:0] sel,      // {int_demod, freq_alt}
  output logic       div_q,
  output logic       div_n,
  output logic       rise
);

  localparam int HMAX_A = (HALF_EXT_F0 > HALF_EXT_F1) ? HALF_EXT_F0 : HALF_EXT_F1;
  localparam int HMAX_B = (HALF_INT_F0 > HALF_INT_F1) ? HALF_INT_F0 : HALF_INT_F1;
  localparam int HMAX   = (HMAX_A > HMAX_B) ? HMAX_A : HMAX_B;
  localparam int HW     = (HMAX > 1) ? $clog2(HMAX) : 1;

  logic [HW-1:0] cnt_q, cnt_n, lim;
  logic          wrap;

  always_comb begin
    unique case (sel)
      2'b00:   lim = HW'(HALF_EXT_F0 - 1);
      2'b01:   lim = HW'(HALF_EXT_F1 - 1);
      2'b10:   lim = HW'(HALF_INT_F0 - 1);
      default: lim = HW'(HALF_INT_F1 - 1);
    endcase
    // >= so that a shrinking ratio never strands the counter
    wrap  = (cnt_q >= lim);
    cnt_n = wrap ? '0 : cnt_q + 1'b1;
    div_n = wrap ? ~div_q : div_q;
    rise  = wrap & ~div_q;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      div_q <= div_n;
    end
  end

endmodule

// File: rtl/clkgate_seq.sv
module clkgate_seq
  import clkgate_pkg::*;
#(
  parameter int GUARD = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_n,
  input  logic intermit,
  input  logic out_dis,
  input  logic rx_off,
  input  logic rx_wake_req,
  input  logic div_n,
  input  logic rise,
  output logic gate_q,
  output logic clk_out_q,
  output logic grant
);

  localparam int GW = $clog2(GUARD + 1);

  gate_st_e      state_q, state_n;
  logic [GW-1:0] gcnt_q, gcnt_n;
  logic          edge_seen, guard_done, gate_want, gate_n, out_n;

  always_comb begin
    edge_seen  = rise & gate_q;
    guard_done = edge_seen && (gcnt_q == GW'(GUARD - 1));
    state_n    = state_q;
    if (!intermit) begin
      state_n = rx_off ? GS_IDLE : GS_RUN;
    end else begin
      unique case (state_q)
        GS_IDLE:  if (rx_wake_req) state_n = GS_LEAD;
        GS_LEAD:  if (guard_done) state_n = GS_RUN;
        GS_RUN:   if (rx_off && !rx_wake_req) state_n = GS_TRAIL;
        default: begin
          if (rx_wake_req)     state_n = GS_LEAD;
          else if (guard_done) state_n = GS_IDLE;
        end
      endcase
    end
    if (state_n != state_q)
      gcnt_n = '0;
    else if (edge_seen && (state_q == GS_LEAD || state_q == GS_TRAIL))
      gcnt_n = gcnt_q + 1'b1;
    else
      gcnt_n = gcnt_q;
  end

  always_comb begin
    gate_want = ~intermit | (state_q != GS_IDLE);
    // gate moves only into a low phase of the divided clock
    gate_n    = div_n ? gate_q : gate_want;
    out_n     = div_n & gate_n & ~out_dis;
    grant     = ~intermit | (state_q == GS_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GS_IDLE;
      gcnt_q  <= '0;
    end else begin
      state_q <= state_n;
      gcnt_q  <= gcnt_n;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      gate_q    <= 1'b0;
      clk_out_q <= 1'b0;
    end else begin
      gate_q    <= gate_n;
      clk_out_q <= out_n;
    end
  end

endmodule

// File: rtl/gated_clkout_ctrl.sv
module gated_clkout_ctrl
  import clkgate_pkg::*;
#(
  parameter int HALF_EXT_F0 = 1,
  parameter int HALF_EXT_F1 = 1,
  parameter int HALF_INT_F0 = 2,
  parameter int HALF_INT_F1 = 2,
  parameter int GUARD       = 4
) (
  input  logic       clk_osc,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [3:0] cfg_wdata,
  input  logic       rx_off,
  input  logic       rx_wake_req,
  output logic       rx_wake_grant,
  output logic       clk_out
);

  ctl_t ctl_q;
  logic div_q, div_n, div_rise, gate_q;

  clkgate_ctl_regs u_regs (
    .clk   (clk_osc),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .ctl_q (ctl_q)
  );

  clkgate_divider #(
    .HALF_EXT_F0 (HALF_EXT_F0),
    .HALF_EXT_F1 (HALF_EXT_F1),
    .HALF_INT_F0 (HALF_INT_F0),
    .HALF_INT_F1 (HALF_INT_F1)
  ) u_div (
    .clk   (clk_osc),
    .por_n (por_n),
    .sel   ({ctl_q.int_demod, ctl_q.freq_alt}),
    .div_q (div_q),
    .div_n (div_n),
    .rise  (div_rise)
  );

  clkgate_seq #(
    .GUARD (GUARD)
  ) u_seq (
    .clk         (clk_osc),
    .por_n       (por_n),
    .rst_n       (rst_n),
    .intermit    (ctl_q.intermit),
    .out_dis     (ctl_q.out_dis),
    .rx_off      (rx_off),
    .rx_wake_req (rx_wake_req),
    .div_n       (div_n),
    .rise        (div_rise),
    .gate_q      (gate_q),
    .clk_out_q   (clk_out),
    .grant       (rx_wake_grant)
  );

endmodule

// File: rtl/clkgate_chk.sv
module clkgate_chk (
  input logic       clk_osc,
  input logic       por_n,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [3:0] ctl_bits,
  input logic       div_q,
  input logic       gate_q,
  input logic       clk_out,
  input logic       rx_wake_grant
);

  // R3: a set disable bit silences the pin from the next edge
  p_disable_low_r3: assert property (@(posedge clk_osc) disable iff (!por_n)
    ctl_bits[0] |=> !clk_out);

  // R7: the gate only moves into a low phase of the divided clock
  p_gate_edge_low_r7: assert property (@(posedge clk_osc) disable iff (!por_n)
    (gate_q != $past(gate_q)) |-> !div_q);

  // R4: with the gate closed no pulse reaches the pin
  p_closed_gate_quiet_r4: assert property (@(posedge clk_osc) disable iff (!por_n)
    !gate_q |-> !clk_out);

  // R5: a grant given in intermittent mode finds the clock already running
  p_grant_has_clock_r5: assert property (@(posedge clk_osc) disable iff (!rst_n || !por_n)
    ($rose(rx_wake_grant) && ctl_bits[1] && $past(ctl_bits[1])) |-> gate_q);

  // R10: control bits hold without a write strobe
  p_ctl_hold_r10: assert property (@(posedge clk_osc) disable iff (!rst_n)
    !cfg_we |=> $stable(ctl_bits));

endmodule

bind gated_clkout_ctrl clkgate_chk u_chk (
  .clk_osc       (clk_osc),
  .por_n         (por_n),
  .rst_n         (rst_n),
  .cfg_we        (cfg_we),
  .ctl_bits      (ctl_q),
  .div_q         (div_q),
  .gate_q        (gate_q),
  .clk_out       (clk_out),
  .rx_wake_grant (rx_wake_grant)
);

// File: tb/test_gated_clkout_ctrl.sv
module test_gated_clkout_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int GUARD_T    = 3;
  localparam int H_E0 = 1, H_E1 = 2, H_I0 = 3, H_I1 = 4;

  logic       clk_osc = 1'b0;
  logic       por_n, rst_n, cfg_we, rx_off, rx_wake_req;
  logic [3:0] cfg_wdata;
  logic       rx_wake_grant, clk_out;

  always #(CLK_PERIOD / 2) clk_osc = ~clk_osc;

  gated_clkout_ctrl #(
    .HALF_EXT_F0 (H_E0), .HALF_EXT_F1 (H_E1),
    .HALF_INT_F0 (H_I0), .HALF_INT_F1 (H_I1),
    .GUARD       (GUARD_T)
  ) i_gated_clkout_ctrl (
    .clk_osc (clk_osc), .por_n (por_n), .rst_n (rst_n),
    .cfg_we (cfg_we), .cfg_wdata (cfg_wdata),
    .rx_off (rx_off), .rx_wake_req (rx_wake_req),
    .rx_wake_grant (rx_wake_grant), .clk_out (clk_out)
  );

  int    n_cmp = 0, n_bad = 0;
  bit    finished = 0;
  int    exp_q[$];
  string tag_q[$];
  bit    strict = 0;
  int    strict_half = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Monitor: measures each high phase and pops the expected width
  logic  mon_prev = 1'b0;
  int    hi_len = 0;
  bit    tracking = 0;
  always @(negedge clk_osc) begin
    if (clk_out && !mon_prev) begin
      hi_len   = 1;
      tracking = (exp_q.size() > 0) || strict;
    end else if (clk_out) begin
      hi_len++;
    end else if (mon_prev && tracking) begin
      if (exp_q.size() > 0) begin
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(hi_len == e, t, hi_len, e);
      end else if (strict) begin
        chk(hi_len == strict_half, "R7", hi_len, strict_half);
      end
      tracking = 0;
    end
    mon_prev = clk_out;
  end

  // Driver: queue expected pulse widths, wait for the monitor to drain them
  task automatic expect_pulses(int n, int half, string req);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(half);
      tag_q.push_back(req);
    end
    for (int k = 0; k < 2000 && exp_q.size() > 0; k++) @(negedge clk_osc);
    if (exp_q.size() > 0) begin
      chk(1'b0, req, exp_q.size(), 0);
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  task automatic write_ctl(logic [3:0] v);
    @(negedge clk_osc);
    cfg_wdata = v;
    cfg_we    = 1'b1;
    @(negedge clk_osc);
    cfg_we    = 1'b0;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk_osc);
  endtask

  task automatic expect_quiet(int n, string req);
    int h = 0;
    repeat (n) begin
      @(negedge clk_osc);
      if (clk_out) h++;
    end
    chk(h == 0, req, h, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    $display("FAIL watchdog: actual 1 expected 0");
    n_bad++;
    n_cmp++;
    finish_run();
  end

  initial begin
    int   r;
    logic pv;
    por_n = 1'b0; rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = 4'h0;
    rx_off = 1'b1; rx_wake_req = 1'b0;
    settle(5);
    chk(clk_out == 1'b0, "R1", int'(clk_out), 0);

    // R8: power-on released, chip reset still held
    por_n = 1'b1;
    settle(4);
    expect_pulses(3, H_E0, "R8");
    chk(rx_wake_grant == 1'b1, "R8", int'(rx_wake_grant), 1);

    // R1: reset ratio after full release
    rst_n = 1'b1;
    settle(4);
    expect_pulses(3, H_E0, "R1");

    // R2: ratio table, bits {freq_alt,int_demod,intermit,out_dis}
    write_ctl(4'b1000); settle(10); expect_pulses(3, H_E1, "R2");
    write_ctl(4'b0100); settle(10); expect_pulses(3, H_I0, "R2");
    write_ctl(4'b1100); settle(10); expect_pulses(3, H_I1, "R2");

    // R10: data without strobe is ignored
    @(negedge clk_osc); cfg_wdata = 4'b0001;
    expect_pulses(2, H_I1, "R10");

    // R9: receiver inputs ignored outside intermittent mode
    write_ctl(4'b0100); settle(10);
    rx_wake_req = 1'b1;
    expect_pulses(2, H_I0, "R9");
    chk(rx_wake_grant == 1'b1, "R9", int'(rx_wake_grant), 1);
    rx_wake_req = 1'b0;

    // R3: disable wins, with and without intermittent mode
    write_ctl(4'b0101); settle(4); expect_quiet(40, "R3");
    rx_off = 1'b0;
    write_ctl(4'b0111); settle(4); expect_quiet(40, "R3");
    rx_off = 1'b1;
    settle(100);

    // R4: intermittent, receiver Off, no request
    write_ctl(4'b0110); settle(30);
    expect_quiet(60, "R4");
    chk(rx_wake_grant == 1'b0, "R4", int'(rx_wake_grant), 0);

    // R5: lead guard, R7 checked by the monitor on every pulse
    strict_half = H_I0;
    strict = 1;
    @(negedge clk_osc);
    rx_wake_req = 1'b1;
    pv = clk_out;
    r  = 0;
    for (int k = 0; k < 500; k++) begin
      @(negedge clk_osc);
      if (clk_out && !pv) r++;
      pv = clk_out;
      if (rx_wake_grant) break;
    end
    chk(rx_wake_grant == 1'b1 && r == GUARD_T, "R5", r, GUARD_T);

    @(negedge clk_osc);
    rx_off = 1'b0;
    rx_wake_req = 1'b0;
    settle(30);

    // R6: trail guard
    @(negedge clk_osc);
    rx_off = 1'b1;
    @(negedge clk_osc);
    pv = clk_out;
    r  = 0;
    repeat (150) begin
      @(negedge clk_osc);
      if (clk_out && !pv) r++;
      pv = clk_out;
    end
    chk(r == GUARD_T, "R6", r, GUARD_T);
    expect_quiet(30, "R6");
    strict = 0;

    finish_run();
  end

endmodule